// File: doc/BRIEF.md
# Windowed Port-I/O Bridge

This block sits between a CPU load/store path and a 16-bit-addressed port bus. A CPU access whose address falls inside a fixed 64 KB physical window becomes a single port cycle. The low 16 bits of the CPU address become the port address. The transfer size passes through with the cycle. When the CPU runs big-endian, halfword and word data are byte-swapped in both directions; bytes always pass unchanged.

An access outside the window never reaches the port bus. It completes on its own one cycle later, and a read of it returns all ones. The CPU side issues one request at a time. `cpu_busy` stays high until the completion pulse `cpu_done` has been given.

Top module: `pio_window_bridge`

## Requirements
- R1: An accepted request whose address lies in 0x1400_0000 to 0x1400_FFFF raises `io_stb` on the next cycle, with `io_addr` equal to the low 16 bits of the CPU address and `io_we` equal to the request's write flag.
- R2: An accepted request outside that range never raises `io_stb`. It gives `cpu_done` one cycle after the request, with `cpu_rdata` equal to 0xFFFF_FFFF.
- R3: Size codes are 0 = byte, 1 = halfword, 2 = word. Code 3 is treated as a word. `io_size` carries 0, 1 or 2 accordingly.
- R4: Byte transfers use bits 7:0 unchanged in both endian modes and in both directions; bits 31:8 are zero.
- R5: Halfword transfers use bits 15:0, with bits 31:16 zero. In little-endian mode the two bytes pass unchanged. In big-endian mode the two bytes are exchanged, for writes and for reads alike.
- R6: Word transfers pass unchanged in little-endian mode. In big-endian mode they are fully byte-reversed (byte 0 swaps with byte 3, byte 1 with byte 2), for writes and for reads alike.
- R7: `io_stb`, `io_addr`, `io_size`, `io_we` and `io_wdata` hold steady until the cycle in which `io_ready` is high; `io_stb` drops on the next cycle.
- R8: `cpu_done` is a one-cycle pulse on the cycle after `io_ready` is seen. For a read, `cpu_rdata` then holds the converted `io_rdata`.
- R9: `cpu_busy` is high from the cycle after acceptance until `cpu_done` has fallen. A request made while `cpu_busy` is high is ignored.
- R10: The endian mode is captured when a request is accepted. Changing `big_endian` during a transfer does not affect that transfer's write or read data.
- R11: After reset, `io_stb`, `cpu_done` and `cpu_busy` are low and `cpu_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | 1 = swap halfword and word data |
| cpu_req | input | 1 | Request strobe, taken when `cpu_busy` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| cpu_addr | input | 32 | CPU physical address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_busy | output | 1 | Transfer in progress |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | 32 | Returned read data |
| io_stb | output | 1 | Port cycle strobe |
| io_we | output | 1 | Port cycle direction |
| io_size | output | 2 | Port transfer size |
| io_addr | output | 16 | Port address |
| io_wdata | output | 32 | Port write data |
| io_rdata | input | 32 | Port read data |
| io_ready | input | 1 | Port cycle complete |

## Verification
The bench sweeps every size code in both endian modes, as reads and as writes. It targets the first and last byte of the window and the addresses just outside each edge. A decoder that is off by one at either edge would strobe the port for a stray address or miss the last port. Read data is checked with distinct bytes in every lane, so swapping the wrong pair or extending into the upper lanes gives a visible mismatch. Partway through each cycle the bench flips the endian input and issues a second request. Sampling the mode late, or taking a request while busy, then corrupts the data or the port address.

// File: rtl/pio_window_bridge.sv
module pio_window_bridge #(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          PW       = 16,
  parameter logic [31:0] WIN_BASE = 32'h1400_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          big_endian,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_size,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_busy,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          io_stb,
  output logic          io_we,
  output logic [1:0]    io_size,
  output logic [PW-1:0] io_addr,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata,
  input  logic          io_ready
);
  localparam int NB = DW / 8;

  function automatic logic [DW-1:0] lanes(input logic [1:0] sz, input logic be, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = '0;
    case (sz)
      2'd0: r[7:0] = d[7:0];
      2'd1: r[15:0] = be ? {d[7:0], d[15:8]} : d[15:0];
      default:
        if (be) for (int i = 0; i < NB; i++) r[8*i +: 8] = d[8*(NB-1-i) +: 8];
        else r = d;
    endcase
    return r;
  endfunction

  logic       take, in_win;
  logic [1:0] sz_n;
  logic       be_q;

  assign take   = cpu_req && !cpu_busy;
  assign in_win = cpu_addr[AW-1:PW] == WIN_BASE[AW-1:PW];
  assign sz_n   = (cpu_size == 2'd3) ? 2'd2 : cpu_size;
  assign cpu_busy = io_stb || cpu_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_stb    <= 1'b0;
      io_we     <= 1'b0;
      io_size   <= 2'd0;
      io_addr   <= '0;
      io_wdata  <= '0;
      be_q      <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      if (take) begin
        if (in_win) begin
          io_stb   <= 1'b1;
          io_we    <= cpu_we;
          io_size  <= sz_n;
          io_addr  <= cpu_addr[PW-1:0];
          io_wdata <= cpu_we ? lanes(sz_n, big_endian, cpu_wdata) : '0;
          be_q     <= big_endian;
        end else begin
          cpu_done  <= 1'b1;
          cpu_rdata <= '1;
        end
      end else if (io_stb && io_ready) begin
        io_stb   <= 1'b0;
        cpu_done <= 1'b1;
        if (!io_we) cpu_rdata <= lanes(io_size, be_q, io_rdata);
      end
    end
  end
endmodule

module pio_window_bridge_chk #(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          PW       = 16,
  parameter logic [31:0] WIN_BASE = 32'h1400_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_busy,
  input logic          cpu_done,
  input logic [DW-1:0] cpu_rdata,
  input logic          io_stb,
  input logic [1:0]    io_size,
  input logic [PW-1:0] io_addr,
  input logic [DW-1:0] io_wdata,
  input logic          io_ready
);
  logic hit;
  assign hit = (cpu_addr >= AW'(WIN_BASE)) && (cpu_addr < AW'(WIN_BASE) + (AW'(1) << PW));

  p_win_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_busy && hit |=> io_stb && io_addr == $past(cpu_addr[PW-1:0]));
  p_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_busy && !hit |=> !io_stb && cpu_done && cpu_rdata == '1);
  p_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_stb && io_size == 2'd0 |-> io_wdata[DW-1:8] == '0);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_stb && !io_ready |=> io_stb && $stable(io_addr) && $stable(io_wdata) && $stable(io_size));
  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    io_stb && io_ready |=> cpu_done && !io_stb);
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    io_stb |-> cpu_busy);
endmodule

bind pio_window_bridge pio_window_bridge_chk #(.AW(AW), .DW(DW), .PW(PW), .WIN_BASE(WIN_BASE)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_busy(cpu_busy),
  .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .io_stb(io_stb), .io_size(io_size),
  .io_addr(io_addr), .io_wdata(io_wdata), .io_ready(io_ready));

// File: tb/test_pio_window_bridge.sv
module test_pio_window_bridge;
  logic clk = 0, rst_n = 0, big_endian = 0, cpu_req = 0, cpu_we = 0, io_ready = 0;
  logic [1:0] cpu_size = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, io_rdata = 0;
  logic cpu_busy, cpu_done, io_stb, io_we;
  logic [1:0] io_size;
  logic [15:0] io_addr;
  logic [31:0] io_wdata, cpu_rdata;
  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pio_window_bridge i_pio_window_bridge (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] conv(input logic [1:0] sz, input logic be, input logic [31:0] d);
    if (sz == 0) return d & 32'hFF;
    if (sz == 1) return be ? ((d & 32'hFF) << 8) | ((d >> 8) & 32'hFF) : d & 32'hFFFF;
    if (!be) return d;
    return ((d & 32'hFF) << 24) | ((d & 32'hFF00) << 8) | ((d >> 8) & 32'hFF00) | (d >> 24);
  endfunction

  task automatic access(input logic [31:0] a, input logic we, input logic [1:0] sz,
                        input logic be, input logic [31:0] wd, input logic [31:0] rd, input int lat);
    logic inw;
    logic [1:0] esz;
    inw = (a >= 32'h1400_0000) && (a <= 32'h1400_FFFF);
    esz = (sz == 3) ? 2'd2 : sz;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd; big_endian = be;
    @(negedge clk);
    cpu_req = 0;
    if (!inw) begin
      chk("R2 no strobe", 32'(io_stb), 0);
      chk("R2 done", 32'(cpu_done), 1);
      chk("R2 all ones", cpu_rdata, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R8 done pulse", 32'(cpu_done), 0);
      return;
    end
    chk("R1 strobe", 32'(io_stb), 1);
    chk("R1 port addr", 32'(io_addr), a & 32'hFFFF);
    chk("R1 direction", 32'(io_we), 32'(we));
    chk("R3 size", 32'(io_size), 32'(esz));
    if (we) chk(sz == 0 ? "R4 byte wdata" : (esz == 1 ? "R5 half wdata" : "R6 word wdata"),
                io_wdata, conv(esz, be, wd));
    for (int k = 0; k < lat; k++) begin
      big_endian = ~be;
      cpu_req = (k == 0); cpu_addr = a ^ 32'h0000_5A5A; cpu_we = ~we;
      @(negedge clk);
      cpu_req = 0;
      chk("R7 strobe held", 32'(io_stb), 1);
      chk("R9 busy, addr kept", 32'(io_addr), a & 32'hFFFF);
      chk("R9 busy", 32'(cpu_busy), 1);
    end
    io_ready = 1; io_rdata = rd;
    @(negedge clk);
    io_ready = 0; io_rdata = 32'hDEAD_BEEF;
    chk("R7 strobe drop", 32'(io_stb), 0);
    chk("R8 done", 32'(cpu_done), 1);
    if (!we) chk(esz == 0 ? "R4 byte rdata" : (esz == 1 ? "R5 half rdata R10" : "R6 word rdata R10"),
                 cpu_rdata, conv(esz, be, rd));
    @(negedge clk);
    chk("R8 done pulse", 32'(cpu_done), 0);
    chk("R9 idle", 32'(cpu_busy), 0);
    big_endian = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [6];
    addrs = '{32'h13FF_FFFF, 32'h1400_0000, 32'h1400_1234, 32'h1400_FFFF, 32'h1401_0000, 32'h0000_0010};
    repeat (3) @(negedge clk);
    chk("R11 strobe", 32'(io_stb), 0);
    chk("R11 done", 32'(cpu_done), 0);
    chk("R11 busy", 32'(cpu_busy), 0);
    chk("R11 rdata", cpu_rdata, 0);
    rst_n = 1;
    for (int ai = 0; ai < 6; ai++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++)
          for (int b = 0; b < 2; b++)
            access(addrs[ai], w[0], s[1:0], b[0], 32'hA1B2_C3D4 + 32'(ai * 16 + s * 4 + w * 2 + b),
                   32'h1122_3344 ^ 32'(s * 8 + b), (s + ai) % 3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule